// File: doc/BRIEF.md
# Block DMA Engine with Per-Byte Bus Arbitration

This block is a single-channel direct memory access engine. It moves a block of bytes between a byte-wide device data port and main memory, and needs no processor help once the transfer has started. Software loads a buffer address and a byte count through a small register port. It then writes a command word that selects the direction. From that point the engine runs the increment-address, decrement-count loop in hardware and raises one interrupt, either when the count reaches zero or as soon as memory reports an error.

The engine is one bus master among several. Before each byte it asks an external arbiter for the bus and keeps that request up until a grant arrives. It performs a single memory access under a simple valid/ready handshake and then drops the request, so the processor can slip its own accesses in between bytes.

The sequencer has six states:
- `ST_IDLE`: waits for a command.
- `ST_DEVWAIT`: waits for the device to be ready.
- `ST_BUSREQ`: requests the bus.
- `ST_XFER`: performs the memory access.
- `ST_STEP`: strobes the device, advances the address and count, and releases the bus.
- `ST_FINISH`: posts the done or error flag.

The transitions are:
- IDLE→DEVWAIT on a valid command with a nonzero count.
- IDLE→FINISH on a zero count or a malformed command.
- DEVWAIT→BUSREQ when the device is ready.
- BUSREQ→XFER on grant.
- XFER→STEP on memory ready.
- XFER→FINISH on memory error.
- STEP→DEVWAIT while bytes remain.
- STEP→FINISH after the last byte.
- FINISH→IDLE always.

Top module: `dma_block_engine`

## Requirements
- R1: After reset, `irq`, `bus_req`, `mem_valid`, `dev_wr` and `dev_rd` are low, and the status word reads 1 (only the idle bit set).
- R2: Register offsets are: 0 buffer address, 1 byte count, 2 command, 3 status. While the engine is idle, the address and count read back the last value written.
- R3: Command bit 0 selects memory-to-device and bit 1 selects device-to-memory. A command with both bits or neither bit set sets the error flag (status bit 2) and raises `irq` without any bus request.
- R4: A valid command issued with a count of zero finishes with the done flag (status bit 1) and `irq`, and never raises `bus_req`.
- R5: `bus_req` is raised only while the device is ready and is held until `bus_gnt`. A memory access happens only under grant. The request drops after every byte, so a block of N bytes shows N falling edges of `bus_req`.
- R6: In memory-to-device mode, each byte is read from memory at the current address and then presented on `dev_wdata` with a one-cycle `dev_wr` pulse, in ascending address order.
- R7: In device-to-memory mode, each byte presented on `dev_rdata` is written to memory at ascending addresses, and `dev_rd` pulses once per byte after the write completes.
- R8: After each byte the address increases by one and the count decreases by one. After a complete block of N bytes from address A, the readback gives address A+N and count 0.
- R9: A completed block produces exactly one rising edge of `irq` and sets the done flag. `irq` stays high until the status register is written.
- R10: A memory error response stops the transfer. It sets the error flag and raises `irq`, and leaves the address at the failing byte and the count at the bytes not yet moved, the failing byte included.
- R11: While busy, a command write is ignored and sets the overrun flag (status bit 3). Address and count writes are also ignored while busy.
- R12: Any write to the status register clears the done, error and overrun flags, and `irq` falls on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register offset select |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt, high while done or error flag is set |
| bus_req | output | 1 | Bus mastership request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_rdata | input | DATA_W | Memory read byte |
| mem_ready | input | 1 | Memory access completed |
| mem_err | input | 1 | Memory access failed |
| dev_ready | input | 1 | Device can accept or supply a byte |
| dev_rdata | input | DATA_W | Byte supplied by device |
| dev_rd | output | 1 | Device byte consumed pulse |
| dev_wdata | output | DATA_W | Byte delivered to device |
| dev_wr | output | 1 | Device byte write pulse |

## Verification
Register reads are combinational, so they are sampled one time step after the address is set on a falling edge. Flag clears take effect on the edge that captures the status write and are checked at the next falling edge. After the final `mem_ready` edge the sequencer spends one cycle in STEP and one in FINISH, so `irq` rises two edges later. A memory error or a zero-count or malformed command raises it one edge after FINISH is entered. The bench therefore waits for `irq` with a bounded loop instead of at a fixed cycle. Device strobes and memory write completions are compared by a falling-edge monitor against a queue of expected address/byte pairs, filled before each command is issued.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVWAIT,
        ST_BUSREQ,
        ST_XFER,
        ST_STEP,
        ST_FINISH
    } seq_state_t;

    // register offsets
    localparam logic [1:0] OFS_ADDR  = 2'd0;
    localparam logic [1:0] OFS_COUNT = 2'd1;
    localparam logic [1:0] OFS_CMD   = 2'd2;
    localparam logic [1:0] OFS_STAT  = 2'd3;

    // command bits
    localparam int CMD_TODEV   = 0;
    localparam int CMD_FROMDEV = 1;

    // status bits
    localparam int STB_IDLE = 0;
    localparam int STB_DONE = 1;
    localparam int STB_ERR  = 2;
    localparam int STB_OVR  = 3;

endpackage

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic [ADDR_W-1:0] ld_addr_val,
    input  logic              ld_cnt,
    input  logic [CNT_W-1:0]  ld_cnt_val,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              cnt_zero,
    output logic              cnt_last
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_count <= '0;
        end else begin
            if (ld_addr)
                cur_addr <= ld_addr_val;
            else if (step)
                cur_addr <= cur_addr + ADDR_ONE;

            if (ld_cnt)
                cur_count <= ld_cnt_val;
            else if (step)
                cur_count <= cur_count - CNT_ONE;
        end
    end

    assign cnt_zero = (cur_count == '0);
    assign cnt_last = (cur_count == CNT_ONE);

    // each byte moves the address up and the count down by one
    assert_step_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cur_count == $past(cur_count) - CNT_ONE) &&
                 (cur_addr == $past(cur_addr) + ADDR_ONE));

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_blk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic              cnt_zero,
    input  logic              fin_done,
    input  logic              fin_err,
    output logic              ld_addr,
    output logic [ADDR_W-1:0] ld_addr_val,
    output logic              ld_cnt,
    output logic [CNT_W-1:0]  ld_cnt_val,
    output logic              start,
    output logic              cmd_bad,
    output logic              dir_to_dev,
    output logic              irq
);

    logic cmd_wr, stat_wr, dir_ok;
    logic done_q, err_q, ovr_q;
    logic unused_wdata;

    assign cmd_wr  = reg_wr_en && (reg_addr == OFS_CMD);
    assign stat_wr = reg_wr_en && (reg_addr == OFS_STAT);
    assign dir_ok  = reg_wdata[CMD_TODEV] ^ reg_wdata[CMD_FROMDEV];

    assign ld_addr     = reg_wr_en && (reg_addr == OFS_ADDR)  && !busy;
    assign ld_cnt      = reg_wr_en && (reg_addr == OFS_COUNT) && !busy;
    assign ld_addr_val = reg_wdata[ADDR_W-1:0];
    assign ld_cnt_val  = reg_wdata[CNT_W-1:0];
    assign start       = cmd_wr && !busy && dir_ok;
    assign cmd_bad     = cmd_wr && !busy && !dir_ok;
    assign dir_to_dev  = reg_wdata[CMD_TODEV];
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (stat_wr) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (start || cmd_bad) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (fin_done) done_q <= 1'b1;
            if (fin_err)  err_q  <= 1'b1;
            if (cmd_wr && busy) ovr_q <= 1'b1;
        end
    end

    assign irq = done_q || err_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_ADDR:  reg_rdata[ADDR_W-1:0] = cur_addr;
            OFS_COUNT: reg_rdata[CNT_W-1:0]  = cur_count;
            OFS_CMD:   reg_rdata = '0;
            OFS_STAT: begin
                reg_rdata[STB_IDLE] = !busy;
                reg_rdata[STB_DONE] = done_q;
                reg_rdata[STB_ERR]  = err_q;
                reg_rdata[STB_OVR]  = ovr_q;
            end
            default:   reg_rdata = '0;
        endcase
    end

    // command while busy leaves a sticky overrun flag
    assert_overrun_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !stat_wr) |=> ovr_q);

    // done is only posted once the count is exhausted
    assert_done_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> cnt_zero);

    // a status write drops the interrupt on the next edge
    assert_status_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !fin_done && !fin_err) |=> !irq);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_blk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_bad,
    input  logic              dir_to_dev,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              dev_ready,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              bus_gnt,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              bus_req,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              step,
    output logic              fin_done,
    output logic              fin_err
);

    seq_state_t        state_q, state_d;
    logic              dir_q;
    logic              err_q;
    logic [DATA_W-1:0] byte_q;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = cnt_zero ? ST_FINISH : ST_DEVWAIT;
                else if (cmd_bad)
                    state_d = ST_FINISH;
            end
            ST_DEVWAIT: if (dev_ready) state_d = ST_BUSREQ;
            ST_BUSREQ:  if (bus_gnt)   state_d = ST_XFER;
            ST_XFER: begin
                if (mem_err)
                    state_d = ST_FINISH;
                else if (mem_ready)
                    state_d = ST_STEP;
            end
            ST_STEP:   state_d = cnt_last ? ST_FINISH : ST_DEVWAIT;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            err_q   <= 1'b0;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && (start || cmd_bad)) begin
                dir_q <= dir_to_dev;
                err_q <= cmd_bad;
            end
            if (state_q == ST_XFER && mem_err)
                err_q <= 1'b1;
            if (state_q == ST_BUSREQ && bus_gnt && !dir_q)
                byte_q <= dev_rdata;
            if (state_q == ST_XFER && mem_ready && !mem_err && dir_q)
                byte_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_req   = (state_q == ST_BUSREQ) || (state_q == ST_XFER);
        mem_valid = (state_q == ST_XFER);
        mem_we    = (state_q == ST_XFER) && !dir_q;
        step      = (state_q == ST_STEP);
        dev_wr    = (state_q == ST_STEP) && dir_q;
        dev_rd    = (state_q == ST_STEP) && !dir_q;
        fin_done  = (state_q == ST_FINISH) && !err_q;
        fin_err   = (state_q == ST_FINISH) && err_q;
        mem_wdata = byte_q;
        dev_wdata = byte_q;
    end

    // request is held until the arbiter answers
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // memory is touched only under grant
    assert_access_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> bus_gnt);

    // device write follows a completed memory read
    assert_devwr_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> $past(mem_valid && mem_ready && !mem_we));

    // device pop follows a completed memory write
    assert_devrd_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> $past(mem_valid && mem_ready && mem_we));

endmodule

// File: rtl/dma_block_engine.sv
module dma_block_engine
    import dma_blk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic              dev_ready,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_rd,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_wr
);

    logic              busy, start, cmd_bad, dir_to_dev;
    logic              ld_addr, ld_cnt, step;
    logic [ADDR_W-1:0] ld_addr_val, cur_addr;
    logic [CNT_W-1:0]  ld_cnt_val, cur_count;
    logic              cnt_zero, cnt_last;
    logic              fin_done, fin_err;

    dma_ctrl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy),
        .cur_addr(cur_addr), .cur_count(cur_count), .cnt_zero(cnt_zero),
        .fin_done(fin_done), .fin_err(fin_err),
        .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
        .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
        .start(start), .cmd_bad(cmd_bad), .dir_to_dev(dir_to_dev), .irq(irq)
    );

    dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
        .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
        .step(step), .cur_addr(cur_addr), .cur_count(cur_count),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last)
    );

    dma_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cmd_bad(cmd_bad), .dir_to_dev(dir_to_dev),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .dev_ready(dev_ready), .dev_rdata(dev_rdata),
        .bus_gnt(bus_gnt), .mem_ready(mem_ready), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .busy(busy), .bus_req(bus_req),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_wdata(dev_wdata),
        .step(step), .fin_done(fin_done), .fin_err(fin_err)
    );

    assign mem_addr = cur_addr;

    // an error response freezes address and remaining count
    assert_err_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_err) |=> (cur_count == $past(cur_count)) &&
                                   (cur_addr == $past(cur_addr)) && !busy == 1'b0);

endmodule

// File: tb/sim_dma_block_engine.sv
module sim_dma_block_engine;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int REG_W  = 32;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic              reg_wr_en = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq, bus_req, bus_gnt;
    logic              mem_valid, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              mem_ready, mem_err;
    logic              dev_ready, dev_rd, dev_wr;
    logic [DATA_W-1:0] dev_rdata, dev_wdata;

    always #10 clk = ~clk;

    dma_block_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .mem_err(mem_err),
        .dev_ready(dev_ready), .dev_rdata(dev_rdata), .dev_rd(dev_rd),
        .dev_wdata(dev_wdata), .dev_wr(dev_wr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // environment: cycle counter, arbiter, memory, device
    logic [15:0] cyc = '0;
    bit stall_mode = 1'b0;
    bit dev_en = 1'b1;
    bit dev_slow = 1'b0;
    bit err_en = 1'b0;
    logic [15:0] err_addr = '0;
    logic owned = 1'b0;
    logic [7:0] src_idx = '0;
    logic [7:0] mem_arr [0:255];

    always @(posedge clk) cyc <= cyc + 16'd1;

    assign bus_gnt   = bus_req && (!stall_mode || (cyc[1:0] == 2'b00) || owned);
    assign dev_ready = dev_en && (!dev_slow || cyc[0]);
    assign dev_rdata = 8'hA0 + src_idx;

    always @(posedge clk) owned <= rst_n && bus_req && bus_gnt;

    always @(posedge clk) if (rst_n && dev_rd) src_idx <= src_idx + 8'd1;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_err   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 256; i++) mem_arr[i] <= init_val(i);
        end else if (mem_valid && !mem_ready && !mem_err) begin
            if (err_en && mem_addr == err_addr) begin
                mem_err <= 1'b1;
            end else begin
                mem_ready <= 1'b1;
                mem_rdata <= mem_arr[mem_addr[7:0]];
                if (mem_we) mem_arr[mem_addr[7:0]] <= mem_wdata;
            end
        end else begin
            mem_ready <= 1'b0;
            mem_err   <= 1'b0;
        end
    end

    // event counters
    int irq_rises = 0, req_falls = 0, req_cycles = 0;
    logic irq_p = 1'b0, req_p = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (irq && !irq_p) irq_rises++;
            if (!bus_req && req_p) req_falls++;
            if (bus_req) req_cycles++;
        end
        irq_p <= irq;
        req_p <= bus_req;
    end

    // scoreboard
    logic [23:0] exp_q[$];

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (dev_wr || (mem_valid && mem_we && mem_ready)) begin
                logic [23:0] got;
                got = dev_wr ? {mem_addr, dev_wdata} : {mem_addr, mem_wdata};
                if (exp_q.size() == 0) begin
                    check(1'b0, dev_wr ? "R6 unexpected device byte" : "R7 unexpected memory write", 32'(got), 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(got == e, dev_wr ? "R6 device byte" : "R7 memory write", 32'(got), 32'(e));
                end
            end
        end
    end

    // register access
    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(irq == 1'b1, tag, 32'(irq), 32'h1);
    endtask

    task automatic push_todev(input int a, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back({16'(a + i), init_val(a + i)});
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int s_irq, s_fall, s_req;
        logic [7:0] s_src;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0 && bus_req == 1'b0 && mem_valid == 1'b0, "R1 outputs idle",
              {29'b0, irq, bus_req, mem_valid}, 32'h0);
        check(dev_wr == 1'b0 && dev_rd == 1'b0, "R1 device strobes", {30'b0, dev_wr, dev_rd}, 32'h0);
        rd_reg(2'd3, r);
        check(r == 32'h1, "R1 status after reset", r, 32'h1);

        // R2 register map readback
        wr_reg(2'd0, 32'h1234);
        wr_reg(2'd1, 32'h0007);
        rd_reg(2'd0, r); check(r == 32'h1234, "R2 address readback", r, 32'h1234);
        rd_reg(2'd1, r); check(r == 32'h0007, "R2 count readback", r, 32'h7);

        // memory to device, 5 bytes (R6 R8 R9 R5)
        wr_reg(2'd0, 32'h20);
        wr_reg(2'd1, 32'd5);
        push_todev(32'h20, 5);
        s_irq = irq_rises; s_fall = req_falls;
        wr_reg(2'd2, 32'h1);
        wait_irq("R9 irq after block");
        check(exp_q.size() == 0, "R6 all bytes delivered", 32'(exp_q.size()), 32'h0);
        rd_reg(2'd0, r); check(r == 32'h25, "R8 final address", r, 32'h25);
        rd_reg(2'd1, r); check(r == 32'h0, "R8 final count", r, 32'h0);
        rd_reg(2'd3, r); check(r == 32'h3, "R9 status idle+done", r, 32'h3);
        repeat (4) @(negedge clk);
        check(irq == 1'b1, "R9 irq stays high", 32'(irq), 32'h1);
        check(irq_rises - s_irq == 1, "R9 single irq edge", 32'(irq_rises - s_irq), 32'h1);
        check(req_falls - s_fall == 5, "R5 bus released per byte", 32'(req_falls - s_fall), 32'h5);

        // R12 status clear
        wr_reg(2'd3, 32'h0);
        check(irq == 1'b0, "R12 irq cleared", 32'(irq), 32'h0);
        rd_reg(2'd3, r); check(r == 32'h1, "R12 status cleared", r, 32'h1);

        // device to memory, 4 bytes, stalled arbiter and slow device (R7 R5)
        stall_mode = 1'b1; dev_slow = 1'b1;
        s_src = src_idx; s_fall = req_falls;
        for (int i = 0; i < 4; i++) exp_q.push_back({16'(32'h40 + i), 8'hA0 + s_src + 8'(i)});
        wr_reg(2'd0, 32'h40);
        wr_reg(2'd1, 32'd4);
        wr_reg(2'd2, 32'h2);
        wait_irq("R9 irq after device block");
        check(exp_q.size() == 0, "R7 all bytes written", 32'(exp_q.size()), 32'h0);
        for (int i = 0; i < 4; i++)
            check(mem_arr[8'h40 + i] == 8'hA0 + s_src + 8'(i), "R7 memory contents",
                  32'(mem_arr[8'h40 + i]), 32'(8'hA0 + s_src + 8'(i)));
        check(src_idx == s_src + 8'd4, "R7 device pops", 32'(src_idx), 32'(s_src + 8'd4));
        check(req_falls - s_fall == 4, "R5 release under stall", 32'(req_falls - s_fall), 32'h4);
        rd_reg(2'd0, r); check(r == 32'h44, "R8 address after write block", r, 32'h44);
        wr_reg(2'd3, 32'h0);
        stall_mode = 1'b0; dev_slow = 1'b0;

        // R4 zero count
        wr_reg(2'd1, 32'd0);
        s_req = req_cycles;
        wr_reg(2'd2, 32'h1);
        wait_irq("R4 irq on zero count");
        rd_reg(2'd3, r); check(r == 32'h3, "R4 done flag", r, 32'h3);
        check(req_cycles == s_req, "R4 no bus request", 32'(req_cycles - s_req), 32'h0);
        wr_reg(2'd3, 32'h0);

        // R3 malformed commands
        wr_reg(2'd1, 32'd3);
        s_req = req_cycles;
        wr_reg(2'd2, 32'h3);
        wait_irq("R3 irq on both bits");
        rd_reg(2'd3, r); check(r == 32'h5, "R3 error flag both bits", r, 32'h5);
        wr_reg(2'd3, 32'h0);
        wr_reg(2'd2, 32'h0);
        wait_irq("R3 irq on no bits");
        rd_reg(2'd3, r); check(r == 32'h5, "R3 error flag no bits", r, 32'h5);
        check(req_cycles == s_req, "R3 no bus request", 32'(req_cycles - s_req), 32'h0);
        rd_reg(2'd1, r); check(r == 32'h3, "R3 count untouched", r, 32'h3);
        wr_reg(2'd3, 32'h0);

        // R10 memory error on the fourth byte
        err_en = 1'b1; err_addr = 16'h63;
        push_todev(32'h60, 3);
        s_irq = irq_rises;
        wr_reg(2'd0, 32'h60);
        wr_reg(2'd1, 32'd6);
        wr_reg(2'd2, 32'h1);
        wait_irq("R10 irq on error");
        rd_reg(2'd3, r); check(r == 32'h5, "R10 error status", r, 32'h5);
        rd_reg(2'd1, r); check(r == 32'h3, "R10 remaining count", r, 32'h3);
        rd_reg(2'd0, r); check(r == 32'h63, "R10 failing address", r, 32'h63);
        check(exp_q.size() == 0, "R10 bytes before error", 32'(exp_q.size()), 32'h0);
        check(irq_rises - s_irq == 1, "R10 single irq", 32'(irq_rises - s_irq), 32'h1);
        err_en = 1'b0;
        wr_reg(2'd3, 32'h0);

        // R11 command overrun while busy
        dev_en = 1'b0;
        wr_reg(2'd0, 32'h30);
        wr_reg(2'd1, 32'd2);
        push_todev(32'h30, 2);
        wr_reg(2'd2, 32'h1);
        wr_reg(2'd2, 32'h2);
        wr_reg(2'd0, 32'h99);
        wr_reg(2'd1, 32'h9);
        rd_reg(2'd3, r); check(r == 32'h8, "R11 overrun while busy", r, 32'h8);
        rd_reg(2'd0, r); check(r == 32'h30, "R11 address write ignored", r, 32'h30);
        rd_reg(2'd1, r); check(r == 32'h2, "R11 count write ignored", r, 32'h2);
        dev_en = 1'b1;
        wait_irq("R11 irq after original block");
        check(exp_q.size() == 0, "R11 original direction kept", 32'(exp_q.size()), 32'h0);
        rd_reg(2'd3, r); check(r == 32'hB, "R11 status done+overrun", r, 32'hB);
        wr_reg(2'd3, 32'h0);
        rd_reg(2'd3, r); check(r == 32'h1, "R12 overrun cleared", r, 32'h1);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule